// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller

This block carries out software flow control for a serial port that is framed elsewhere. Every received character passes through it on its way to the receive queue. When the feature is on, a character equal to the programmed stop value halts the local transmitter. A character equal to the programmed go value releases the transmitter. Neither control character is passed on to the queue. In an optional mode, any ordinary character also releases a halted transmitter, and that character is still delivered.

On the local side the block watches the receive queue fill level. When the level reaches the halt threshold it asks the transmitter to send the stop value, once. When the level later drops to the resume threshold it asks for the go value, once. Each request goes ahead of queued transmit data. A request is raised only between characters and is held until the transmitter acknowledges it. The transmitter starts no new data character while `tx_suspend` or `ins_req` is high. The threshold values are the same ones used for hardware flow control, and hardware flow control is not expected to run at the same time.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_suspend`, `ins_req` and `rxq_wr` are all 0.
- R2: With `cfg_enable`=1, a received character equal to `cfg_xoff_char` is not written to the receive queue. `tx_suspend` is 1 in the cycle after the strobe when `tx_busy` was 0 at that edge. Any 8-bit value, 0x0F included, is a valid stop value.
- R3: `tx_suspend` rises only at an edge where `tx_busy` is sampled 0. A stop character that arrives during a character in progress takes effect at the first clock edge with `tx_busy` low.
- R4: With `cfg_enable`=1, a received character equal to `cfg_xon_char` is not written to the queue, and `tx_suspend` is 0 from the next cycle.
- R5: Any other received character appears on `rxq_wr`/`rxq_data` in the next cycle with an unchanged value. With `cfg_xany`=0 it does not change `tx_suspend`.
- R6: With `cfg_xany`=1, an ordinary character received while halted clears `tx_suspend` in the next cycle and is still delivered.
- R7: With `cfg_enable`=0, every character is delivered, including the control values. `tx_suspend` and `ins_req` are 0 from the next cycle on.
- R8: When the fill level is at or above `cfg_halt_lvl` while the far end is running, a single request is made with `ins_char` = `cfg_xoff_char`. `ins_req` holds until `ins_ack` is sampled high and is 0 in the cycle after that.
- R9: After the stop request has been acknowledged, no further request is made until the level is at or below `cfg_resume_lvl`. Then a single request is made with `ins_char` = `cfg_xon_char`.
- R10: `ins_req` rises only at an edge where `tx_busy` is sampled 0, so a request never cuts into a character in progress.
- R11: When the go and stop values are equal, a matching character is treated as a stop character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Software flow control on |
| cfg_xany | input | 1 | Any ordinary character releases a halted transmitter |
| cfg_xon_char | input | 8 | Go character value |
| cfg_xoff_char | input | 8 | Stop character value |
| cfg_halt_lvl | input | LVL_W | Fill level at which the stop value is requested |
| cfg_resume_lvl | input | LVL_W | Fill level at which the go value is requested |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_level | input | LVL_W | Receive queue occupancy |
| tx_busy | input | 1 | Transmitter is shifting a character |
| ins_ack | input | 1 | Transmitter has taken the inserted character |
| rxq_wr | output | 1 | Write strobe toward the receive queue |
| rxq_data | output | 8 | Character toward the receive queue |
| tx_suspend | output | 1 | Transmitter must not start a data character |
| ins_req | output | 1 | Request to send a control character |
| ins_char | output | 8 | Control character to send |

## Verification
The receive path is driven with ordinary bytes, the stop and go values, the stop value 0x0F, and equal stop and go values. This separates matching and discarding from plain forwarding, and stop priority from go. The same stop value is sent once with the transmitter idle and once during a busy stretch, which tells an immediate halt from a deferred one. The any-character mode is set on and off around the same ordinary byte. The fill level is raised past the halt point in steps and then lowered to the resume point, with the transmitter busy when the level first crosses. Each request is counted by type, and the busy window shows that requests wait for a character boundary.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int CHAR_W = 8;

  typedef logic [CHAR_W-1:0] char_t;

  // State of the far end as seen by the level monitor
  typedef enum logic [1:0] {
    LM_RUN       = 2'd0,
    LM_XOFF_PEND = 2'd1,
    LM_HALTED    = 2'd2,
    LM_XON_PEND  = 2'd3
  } lm_state_e;
endpackage

// File: rtl/xfc_rx_filter.sv
module xfc_rx_filter
  import xfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_enable,
  input  logic  cfg_xany,
  input  char_t cfg_xon_char,
  input  char_t cfg_xoff_char,
  input  logic  rx_valid,
  input  char_t rx_data,
  output logic  rxq_wr,
  output char_t rxq_data,
  output logic  halt_next
);
  logic  halt_q;
  logic  is_stop, is_go, fwd;

  // stop match is checked first, so equal values mean stop
  assign is_stop = cfg_enable && (rx_data == cfg_xoff_char);
  assign is_go   = cfg_enable && !is_stop && (rx_data == cfg_xon_char);
  assign fwd     = rx_valid && !is_stop && !is_go;

  always_comb begin
    halt_next = halt_q;
    if (!cfg_enable)
      halt_next = 1'b0;
    else if (rx_valid) begin
      if (is_stop)
        halt_next = 1'b1;
      else if (is_go)
        halt_next = 1'b0;
      else if (cfg_xany)
        halt_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q   <= 1'b0;
      rxq_wr   <= 1'b0;
      rxq_data <= '0;
    end else begin
      halt_q <= halt_next;
      rxq_wr <= fwd;
      if (fwd)
        rxq_data <= rx_data;
    end
  end
endmodule

// File: rtl/xfc_susp_gate.sv
module xfc_susp_gate (
  input  logic clk,
  input  logic rst,
  input  logic halt_next,
  input  logic tx_busy,
  output logic tx_suspend
);
  // a halt is applied only between characters; release is immediate
  always_ff @(posedge clk) begin
    if (rst)
      tx_suspend <= 1'b0;
    else
      tx_suspend <= halt_next && (tx_suspend || !tx_busy);
  end
endmodule

// File: rtl/xfc_level_mon.sv
module xfc_level_mon
  import xfc_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  char_t            cfg_xon_char,
  input  char_t            cfg_xoff_char,
  input  logic [LVL_W-1:0] cfg_halt_lvl,
  input  logic [LVL_W-1:0] cfg_resume_lvl,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             tx_busy,
  input  logic             ins_ack,
  output logic             ins_req,
  output char_t            ins_char
);
  lm_state_e st_q, st_d;
  logic      pending, taken, raise;

  assign pending = (st_q == LM_XOFF_PEND) || (st_q == LM_XON_PEND);
  assign taken   = ins_req && ins_ack;
  assign raise   = pending && !ins_req && !tx_busy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LM_RUN:       if (fifo_level >= cfg_halt_lvl)   st_d = LM_XOFF_PEND;
      LM_XOFF_PEND: if (taken)                        st_d = LM_HALTED;
      LM_HALTED:    if (fifo_level <= cfg_resume_lvl) st_d = LM_XON_PEND;
      LM_XON_PEND:  if (taken)                        st_d = LM_RUN;
      default:                                        st_d = LM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg_enable) begin
      st_q     <= LM_RUN;
      ins_req  <= 1'b0;
      ins_char <= '0;
    end else begin
      st_q    <= st_d;
      ins_req <= (ins_req && !ins_ack) || raise;
      if (raise)
        ins_char <= (st_q == LM_XOFF_PEND) ? cfg_xoff_char : cfg_xon_char;
    end
  end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xfc_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_xany,
  input  logic [7:0]       cfg_xon_char,
  input  logic [7:0]       cfg_xoff_char,
  input  logic [LVL_W-1:0] cfg_halt_lvl,
  input  logic [LVL_W-1:0] cfg_resume_lvl,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             tx_busy,
  input  logic             ins_ack,
  output logic             rxq_wr,
  output logic [7:0]       rxq_data,
  output logic             tx_suspend,
  output logic             ins_req,
  output logic [7:0]       ins_char
);
  logic halt_next;

  xfc_rx_filter u_rx (
    .clk           (clk),
    .rst           (rst),
    .cfg_enable    (cfg_enable),
    .cfg_xany      (cfg_xany),
    .cfg_xon_char  (cfg_xon_char),
    .cfg_xoff_char (cfg_xoff_char),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rxq_wr        (rxq_wr),
    .rxq_data      (rxq_data),
    .halt_next     (halt_next)
  );

  xfc_susp_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .halt_next  (halt_next),
    .tx_busy    (tx_busy),
    .tx_suspend (tx_suspend)
  );

  xfc_level_mon #(.LVL_W(LVL_W)) u_lvl (
    .clk            (clk),
    .rst            (rst),
    .cfg_enable     (cfg_enable),
    .cfg_xon_char   (cfg_xon_char),
    .cfg_xoff_char  (cfg_xoff_char),
    .cfg_halt_lvl   (cfg_halt_lvl),
    .cfg_resume_lvl (cfg_resume_lvl),
    .fifo_level     (fifo_level),
    .tx_busy        (tx_busy),
    .ins_ack        (ins_ack),
    .ins_req        (ins_req),
    .ins_char       (ins_char)
  );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic [7:0]       cfg_xon_char,
  input logic [7:0]       cfg_xoff_char,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             tx_busy,
  input logic             ins_ack,
  input logic             rxq_wr,
  input logic [7:0]       rxq_data,
  input logic             tx_suspend,
  input logic             ins_req
);
  p_stop_dropped_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_enable && rx_data == cfg_xoff_char) |=> !rxq_wr);

  p_halt_at_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_suspend) |-> !$past(tx_busy));

  p_go_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_enable && rx_data == cfg_xon_char) |=> !rxq_wr);

  p_plain_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_enable && rx_data != cfg_xon_char && rx_data != cfg_xoff_char)
      |=> (rxq_wr && rxq_data == $past(rx_data)));

  p_off_free_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (!tx_suspend && !ins_req));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ins_req && !ins_ack && cfg_enable) |=> ins_req);

  p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (ins_req && ins_ack) |=> !ins_req);

  p_req_at_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ins_req) |-> !$past(tx_busy));
endmodule

bind xonxoff_flow_ctrl xfc_checker #(.LVL_W(LVL_W)) u_xfc_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_enable    (cfg_enable),
  .cfg_xon_char  (cfg_xon_char),
  .cfg_xoff_char (cfg_xoff_char),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .tx_busy       (tx_busy),
  .ins_ack       (ins_ack),
  .rxq_wr        (rxq_wr),
  .rxq_data      (rxq_data),
  .tx_suspend    (tx_suspend),
  .ins_req       (ins_req)
);

// File: tb/xonxoff_flow_ctrl_bench.sv
module xonxoff_flow_ctrl_bench;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0, cfg_xany = 1'b0;
  logic [7:0] cfg_xon_char = 8'h11, cfg_xoff_char = 8'h13;
  logic [LW-1:0] cfg_halt_lvl = 7'd48, cfg_resume_lvl = 7'd16;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [LW-1:0] fifo_level = '0;
  logic tx_busy = 1'b0;
  logic ins_ack = 1'b0;
  logic rxq_wr, tx_suspend, ins_req;
  logic [7:0] rxq_data, ins_char;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, ack_en = 1;
  int n_xoff_req = 0, n_xon_req = 0;
  bit prev_req = 0;

  // reference state
  bit m_seen, m_susp, m_wr, m_req;
  logic [7:0] m_data, m_char;
  int m_st; // 0 run, 1 stop pending, 2 halted, 3 go pending

  always #5 clk = ~clk;

  xonxoff_flow_ctrl #(.LVL_W(LW)) u_xonxoff_flow_ctrl (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_xany(cfg_xany),
    .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
    .cfg_halt_lvl(cfg_halt_lvl), .cfg_resume_lvl(cfg_resume_lvl),
    .rx_valid(rx_valid), .rx_data(rx_data), .fifo_level(fifo_level),
    .tx_busy(tx_busy), .ins_ack(ins_ack), .rxq_wr(rxq_wr), .rxq_data(rxq_data),
    .tx_suspend(tx_suspend), .ins_req(ins_req), .ins_char(ins_char));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (rst) begin
      m_seen = 0; m_susp = 0; m_wr = 0; m_req = 0; m_st = 0;
      m_data = 8'h00; m_char = 8'h00;
    end else begin
      bit nseen, nwr, oreq;
      int ost;
      nseen = m_seen; nwr = 0;
      if (!cfg_enable) begin
        nseen = 0; nwr = rx_valid;
      end else if (rx_valid) begin
        if (rx_data == cfg_xoff_char) nseen = 1;
        else if (rx_data == cfg_xon_char) nseen = 0;
        else begin nwr = 1; if (cfg_xany) nseen = 0; end
      end
      m_wr = nwr;
      if (nwr) m_data = rx_data;
      m_susp = nseen && (m_susp || !tx_busy);
      m_seen = nseen;
      if (!cfg_enable) begin
        m_st = 0; m_req = 0; m_char = 8'h00;
      end else begin
        ost = m_st; oreq = m_req;
        if (ost == 0 && fifo_level >= cfg_halt_lvl) m_st = 1;
        else if (ost == 1 && oreq && ins_ack) m_st = 2;
        else if (ost == 2 && fifo_level <= cfg_resume_lvl) m_st = 3;
        else if (ost == 3 && oreq && ins_ack) m_st = 0;
        m_req = (oreq && !ins_ack) || ((ost == 1 || ost == 3) && !oreq && !tx_busy);
        if (!oreq && m_req) m_char = (ost == 1) ? cfg_xoff_char : cfg_xon_char;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tx_suspend == m_susp, "R3 tx_suspend vs model", tx_suspend, m_susp);
      chk(rxq_wr == m_wr, "R5 rxq_wr vs model", rxq_wr, m_wr);
      if (m_wr) chk(rxq_data == m_data, "R5 rxq_data vs model", rxq_data, m_data);
      chk(ins_req == m_req, "R8 ins_req vs model", ins_req, m_req);
      if (m_req) chk(ins_char == m_char, "R8 ins_char vs model", ins_char, m_char);
      if (ins_req && !prev_req) begin
        if (ins_char == cfg_xoff_char) n_xoff_req++;
        else n_xon_req++;
      end
      prev_req = ins_req;
      ins_ack = ack_en && ins_req && !ins_ack;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [7:0] c);
    @(negedge clk); rx_valid = 1; rx_data = c;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk(!tx_suspend && !ins_req && !rxq_wr, "R1 reset outputs", {tx_suspend, ins_req, rxq_wr}, 0);
    @(negedge clk); rst = 0; cfg_enable = 1;
    idle(2);
    chk(!tx_suspend && !ins_req && !rxq_wr, "R1 after reset", {tx_suspend, ins_req, rxq_wr}, 0);

    send(8'h41);
    chk(rxq_wr && rxq_data == 8'h41, "R5 plain byte delivered", rxq_data, 8'h41);
    send(8'h13);
    chk(!rxq_wr, "R2 stop byte dropped", rxq_wr, 0);
    chk(tx_suspend, "R2 halt applied", tx_suspend, 1);
    send(8'h42);
    chk(rxq_wr && tx_suspend, "R5 plain byte keeps halt", {rxq_wr, tx_suspend}, 2'b11);
    send(8'h11);
    chk(!rxq_wr && !tx_suspend, "R4 go byte dropped and released", {rxq_wr, tx_suspend}, 0);

    // stop during a character in progress
    @(negedge clk); tx_busy = 1;
    send(8'h13);
    chk(!tx_suspend, "R3 halt deferred while busy", tx_suspend, 0);
    idle(3);
    chk(!tx_suspend, "R3 halt still deferred", tx_suspend, 0);
    tx_busy = 0;
    @(negedge clk);
    chk(tx_suspend, "R3 halt at character gap", tx_suspend, 1);

    cfg_xany = 1;
    send(8'h43);
    chk(rxq_wr && rxq_data == 8'h43 && !tx_suspend, "R6 any byte releases", {rxq_wr, tx_suspend}, 2'b10);
    cfg_xany = 0;

    cfg_xoff_char = 8'h0F;
    send(8'h0F);
    chk(tx_suspend && !rxq_wr, "R2 stop value 0x0F", {tx_suspend, rxq_wr}, 2'b10);
    send(8'h11);
    chk(!tx_suspend, "R4 release after 0x0F", tx_suspend, 0);

    cfg_xon_char = 8'h55; cfg_xoff_char = 8'h55;
    send(8'h55);
    chk(tx_suspend && !rxq_wr, "R11 equal values act as stop", {tx_suspend, rxq_wr}, 2'b10);
    cfg_xon_char = 8'h11; cfg_xoff_char = 8'h13;
    send(8'h11);

    cfg_enable = 0;
    send(8'h13);
    chk(rxq_wr && rxq_data == 8'h13 && !tx_suspend, "R7 disabled passes stop value", rxq_data, 8'h13);
    send(8'h11);
    chk(rxq_wr && rxq_data == 8'h11, "R7 disabled passes go value", rxq_data, 8'h11);
    fifo_level = 7'd60;
    idle(4);
    chk(!ins_req, "R7 no request when disabled", ins_req, 0);
    fifo_level = 7'd0;
    cfg_enable = 1;
    idle(2);

    // level thresholds
    tx_busy = 1;
    fifo_level = 7'd50;
    idle(5);
    chk(!ins_req, "R10 request waits for gap", ins_req, 0);
    tx_busy = 0;
    idle(6);
    chk(n_xoff_req == 1, "R8 one stop request", n_xoff_req, 1);
    for (int l = 51; l < 64; l++) begin fifo_level = l[LW-1:0]; @(negedge clk); end
    fifo_level = 7'd30; idle(5);
    fifo_level = 7'd17; idle(5);
    chk(n_xoff_req == 1 && n_xon_req == 0, "R9 no repeat above resume", n_xon_req, 0);
    fifo_level = 7'd16;
    idle(6);
    chk(n_xon_req == 1, "R9 one go request", n_xon_req, 1);
    fifo_level = 7'd5; idle(4);
    chk(n_xon_req == 1 && n_xoff_req == 1, "R9 no extra go request", n_xon_req, 1);

    // held request without acknowledge
    ack_en = 0;
    fifo_level = 7'd48;
    idle(8);
    chk(ins_req && ins_char == 8'h13, "R8 request held until ack", ins_req, 1);
    ack_en = 1;
    idle(4);
    chk(!ins_req, "R8 request dropped after ack", ins_req, 0);

    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule